// File: doc/BRIEF.md
# Two-Lane Pulse Width Modulator with Staged Period and Duty

This block holds two pulse-width-modulation lanes, called x (lane 0) and y (lane 1). Each lane has its own counter, which steps once on every clock cycle where the shared `tick` input is high. Software drives the block through a byte-wide write port. For each lane it sets an enable bit, a polarity bit, an alignment bit, a period and a duty value. The lane then produces a repeating waveform. In edge-aligned mode the counter runs upward and wraps. In center-aligned mode the counter ramps up and then back down.

Period and duty writes first land in staging registers. A lane moves them into its live compare registers at only three moments: when a period finishes, when software writes the lane's counter, or at any time while the lane is disabled. This means a write never cuts into a period that is already running.

A join bit fuses the two lanes into one 16-bit lane. Lane x supplies the upper byte of period and duty, and lane y supplies the lower byte. Lane y's control bits govern the joined lane, and the joined waveform appears on lane y's pin.

Top module: `pwm_pair`

## Requirements
- R1: Write map, with `wr_addr` decoded on a write where `wr_en` is high:
  - 0 and 1 are the control bytes of lanes x and y (bit0 enable, bit1 polarity, bit2 center mode).
  - 2 holds the join bit in bit0.
  - 3 and 4 are the staged periods of x and y.
  - 5 and 6 are the staged duties of x and y.
  - 7 and 8 are counter writes for x and y.
- R2: While `rst` is high and after it, every register is zero and both `pwm_out` bits are 1.
- R3: In edge mode, a lane's counter takes the values 0, 1, …, P-1 and then 0 again, stepping only on cycles with `tick` high.
  - The pin is at the active level while the counter is below the duty D, and at the inactive level otherwise.
  - The active level equals the polarity bit; the inactive level is its complement.
- R4: In center mode, the counter follows 0, 1, …, P-1, P-1, …, 1, 0, so one period lasts 2P ticks. The pin is active while the counter is below D.
- R5: A duty of 0 keeps the pin inactive for the whole period. A duty greater than or equal to P keeps it active for the whole period.
- R6: While a lane is disabled, its counter is held at 0 and its pin sits at the inactive level of its polarity. After enabling, counting begins from 0.
- R7: Staged period and duty values reach the live registers only at the end of a period, on a counter write, or while the lane is disabled.
- R8: A counter write sets the lane's counter to 0, starts a new period and loads the staged period and duty.
- R9: A write to a control byte while that lane is enabled leaves its center bit unchanged. The enable and polarity bits are still written.
- R10: With the join bit set, lane y runs a 16-bit counter with period {x,y} and duty {x,y} under y's control bits, and drives the result on `pwm_out[1]`.
  - Lane x is idle: its counter write has no effect, and `pwm_out[0]` stays at x's inactive level.
- R11: A write to the join bit takes effect only while both lanes are disabled.
- R12: A period of 200 with a duty of 100 gives 100 active ticks out of 200 in edge mode, and 200 out of 400 in center mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable; counters step on cycles where it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 2 | Waveform pins, bit 0 for lane x, bit 1 for lane y |

## Verification
The bench sweeps small periods against every duty from 0 to P+1, in both modes and both polarities, on both lanes, with one lane's tick gated to every other cycle. A design that is off by one at the wrap, or that holds the top or bottom of the center ramp for the wrong number of ticks, drifts out of phase within two periods.

Period and duty are rewritten mid-period, and the counter is written after a period value has been staged. A design that loads values early shows a short period where the old one should still run. A design that ignores the counter write never restarts.

Alignment changes are attempted while a lane runs, and the join bit is written while the pair runs. A design that accepts either change shows the wrong waveform shape or an 8-bit period. The joined 300-tick period also checks the byte order of the two halves.

// File: rtl/pwm_pair_pkg.sv
`timescale 1ns/1ps
package pwm_pair_pkg;

    localparam int NLANE  = 2;
    localparam int ADDR_W = 4;

    // write address map
    localparam logic [ADDR_W-1:0] ADR_CTRL0 = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_JOIN  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_PER0  = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_DTY0  = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_CNT0  = 4'd7;

    typedef struct packed {
        logic center;
        logic pol;
        logic en;
    } lane_ctrl_t;

    function automatic logic [ADDR_W-1:0] lane_addr(input logic [ADDR_W-1:0] base, input int lane);
        return base + ADDR_W'(lane);
    endfunction

    function automatic logic pin_level(input logic active, input logic pol);
        return active ? pol : ~pol;
    endfunction

endpackage

// File: rtl/pwm_pair_regs.sv
`timescale 1ns/1ps
module pwm_pair_regs
    import pwm_pair_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [CH_W-1:0]                   wr_data,
    output lane_ctrl_t [NLANE-1:0]            ctrl_o,
    output logic [NLANE-1:0][CH_W-1:0]        per_o,
    output logic [NLANE-1:0][CH_W-1:0]        dty_o,
    output logic                              join_o,
    output logic [NLANE-1:0]                  cnt_wr_o
);

    lane_ctrl_t [NLANE-1:0]     ctrl_q;
    logic [NLANE-1:0][CH_W-1:0] per_q;
    logic [NLANE-1:0][CH_W-1:0] dty_q;
    logic                       join_q;
    logic                       any_en;

    always_comb begin
        any_en = 1'b0;
        for (int i = 0; i < NLANE; i++) any_en = any_en | ctrl_q[i].en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            per_q  <= '0;
            dty_q  <= '0;
            join_q <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NLANE; i++) begin
                if (wr_addr == lane_addr(ADR_CTRL0, i)) begin
                    ctrl_q[i].en  <= wr_data[0];
                    ctrl_q[i].pol <= wr_data[1];
                    // alignment only moves while the lane is stopped
                    if (!ctrl_q[i].en) ctrl_q[i].center <= wr_data[2];
                end
                if (wr_addr == lane_addr(ADR_PER0, i)) per_q[i] <= wr_data;
                if (wr_addr == lane_addr(ADR_DTY0, i)) dty_q[i] <= wr_data;
            end
            if (wr_addr == ADR_JOIN && !any_en) join_q <= wr_data[0];
        end
    end

    always_comb begin
        for (int i = 0; i < NLANE; i++)
            cnt_wr_o[i] = wr_en && (wr_addr == lane_addr(ADR_CNT0, i));
    end

    assign ctrl_o = ctrl_q;
    assign per_o  = per_q;
    assign dty_o  = dty_q;
    assign join_o = join_q;

    for (genvar g = 0; g < NLANE; g++) begin : g_chk
        // R9: alignment frozen while running
        a_r9_center_locked: assert property (@(posedge clk) disable iff (rst)
            ctrl_q[g].en |=> $stable(ctrl_q[g].center));
    end

    // R11: join frozen while either lane runs
    a_r11_join_locked: assert property (@(posedge clk) disable iff (rst)
        any_en |=> $stable(join_q));

endmodule

// File: rtl/pwm_pair_engine.sv
`timescale 1ns/1ps
module pwm_pair_engine
    import pwm_pair_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         en,
    input  logic         pol,
    input  logic         center,
    input  logic         clr,
    input  logic [W-1:0] per_stage,
    input  logic [W-1:0] dty_stage,
    output logic         out
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] per_q;
    logic [W-1:0] dty_q;
    logic         down_q;
    logic         at_top;
    logic         at_floor;
    logic         wrap_evt;
    logic         reload;

    assign at_top   = (per_q <= W'(1)) || (cnt_q == per_q - W'(1));
    assign at_floor = (cnt_q == '0);
    assign wrap_evt = tick && (center ? (down_q && at_floor) : at_top);
    assign reload   = !en || clr || wrap_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            per_q  <= '0;
            dty_q  <= '0;
            down_q <= 1'b0;
        end else begin
            if (reload) begin
                per_q <= per_stage;
                dty_q <= dty_stage;
            end
            if (!en || clr) begin
                cnt_q  <= '0;
                down_q <= 1'b0;
            end else if (tick) begin
                if (!center) begin
                    cnt_q <= at_top ? '0 : cnt_q + W'(1);
                end else if (!down_q) begin
                    if (at_top) down_q <= 1'b1;
                    else        cnt_q  <= cnt_q + W'(1);
                end else begin
                    if (at_floor) down_q <= 1'b0;
                    else          cnt_q  <= cnt_q - W'(1);
                end
            end
        end
    end

    assign out = pin_level(en && (cnt_q < dty_q), pol);

    // R3: counter stays inside the live period
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
        (en && per_q > W'(1)) |-> (cnt_q < per_q));

    // R3: edge mode wraps to zero after the last count
    a_r3_left_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && !center && !clr && tick && per_q > W'(1) && cnt_q == per_q - W'(1))
        |=> (cnt_q == '0));

    // R6: a stopped lane parks its counter at zero
    a_r6_off_zero: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

    // R7: live values hold between reload points
    a_r7_live_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && !wrap_evt) |=> ($stable(per_q) && $stable(dty_q)));

endmodule

// File: rtl/pwm_pair.sv
`timescale 1ns/1ps
module pwm_pair
    import pwm_pair_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CH_W-1:0]   wr_data,
    output logic [NLANE-1:0]  pwm_out
);

    localparam int W = 2 * CH_W;

    lane_ctrl_t [NLANE-1:0]     ctrl;
    logic [NLANE-1:0][CH_W-1:0] per;
    logic [NLANE-1:0][CH_W-1:0] dty;
    logic                       join_on;
    logic [NLANE-1:0]           cnt_wr;

    pwm_pair_regs #(.CH_W(CH_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl_o   (ctrl),
        .per_o    (per),
        .dty_o    (dty),
        .join_o   (join_on),
        .cnt_wr_o (cnt_wr)
    );

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        logic         l_en;
        logic         l_clr;
        logic [W-1:0] l_per;
        logic [W-1:0] l_dty;

        if (i == NLANE - 1) begin : g_low
            // low-byte lane governs the joined pair
            assign l_en  = ctrl[i].en;
            assign l_clr = cnt_wr[i];
            assign l_per = join_on ? {per[0], per[i]} : {{CH_W{1'b0}}, per[i]};
            assign l_dty = join_on ? {dty[0], dty[i]} : {{CH_W{1'b0}}, dty[i]};
        end else begin : g_high
            assign l_en  = ctrl[i].en & ~join_on;
            assign l_clr = cnt_wr[i] & ~join_on;
            assign l_per = {{CH_W{1'b0}}, per[i]};
            assign l_dty = {{CH_W{1'b0}}, dty[i]};
        end

        pwm_pair_engine #(.W(W)) u_eng (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .en        (l_en),
            .pol       (ctrl[i].pol),
            .center    (ctrl[i].center),
            .clr       (l_clr),
            .per_stage (l_per),
            .dty_stage (l_dty),
            .out       (pwm_out[i])
        );
    end

    // R10: high-byte lane is parked while joined
    a_r10_high_idle: assert property (@(posedge clk) disable iff (rst)
        join_on |-> (pwm_out[0] == ~ctrl[0].pol));

endmodule

// File: tb/pwm_pair_test.sv
`timescale 1ns/1ps
module pwm_pair_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] pwm_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    pwm_pair #(.CH_W(8)) uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    function automatic bit act_at(int k, int p, int d, bit ctr);
        int m;
        int v;
        if (ctr) begin
            m = k % (2 * p);
            v = (m < p) ? m : 2 * p - 1 - m;
        end else begin
            v = k % p;
        end
        return (d != 0) && (v < d);
    endfunction

    function automatic int lvl(bit a, bit pol);
        return a ? int'(pol) : int'(!pol);
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R1 R6: stop lane, stage values, start with chosen mode
    task automatic cfg(int lane, int p, int d, bit ctr, bit pol);
        wr(lane, 0);
        chk("R1 R6 stopped lane inactive", int'(pwm_out[lane]), 1);
        wr(3 + lane, p);
        wr(5 + lane, d);
        wr(lane, 1 + 2 * int'(pol) + 4 * int'(ctr));
    endtask

    task automatic run_lane(int lane, int p, int d, bit ctr, bit pol, int nsamp, int div, string tag);
        int k = 0;
        for (int s = 0; s < nsamp; s++) begin
            bit tk;
            chk(tag, int'(pwm_out[lane]), lvl(act_at(k, p, d, ctr), pol));
            tk = ((s % div) == 0);
            tick = tk;
            @(negedge clk);
            if (tk) k++;
        end
        tick = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int highs;
        repeat (3) @(negedge clk);
        chk("R2 pins during reset", int'(pwm_out), 3);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 pins after reset", int'(pwm_out), 3);

        // R3 R4 R5: sweep of small periods, all duties, both modes and polarities
        for (int lane = 0; lane < 2; lane++)
            for (int ctr = 0; ctr < 2; ctr++)
                for (int pol = 0; pol < 2; pol++)
                    for (int p = 1; p <= 5; p++)
                        for (int d = 0; d <= p + 1; d++) begin
                            string tg;
                            int div;
                            tg = ctr ? "R4 center sweep" : "R3 edge sweep";
                            if (d == 0 || d >= p) tg = {tg, " R5"};
                            div = lane + 1;
                            cfg(lane, p, d, bit'(ctr), bit'(pol));
                            run_lane(lane, p, d, bit'(ctr), bit'(pol),
                                     (ctr ? 4 * p : 2 * p) * div + 2, div, tg);
                        end

        // R12: 200/100 gives half duty in both modes
        cfg(0, 200, 100, 1'b0, 1'b1);
        highs = 0;
        for (int s = 0; s < 200; s++) begin
            highs += int'(pwm_out[0]);
            @(negedge clk);
        end
        chk("R12 edge half duty", highs, 100);
        cfg(0, 200, 100, 1'b1, 1'b1);
        highs = 0;
        for (int s = 0; s < 400; s++) begin
            highs += int'(pwm_out[0]);
            @(negedge clk);
        end
        chk("R12 center half duty", highs, 200);

        // R7: mid-period rewrite waits for period end
        cfg(0, 10, 3, 1'b0, 1'b1);
        for (int s = 0; s < 50; s++) begin
            chk("R7 staged values deferred", int'(pwm_out[0]),
                (s < 20) ? lvl(act_at(s, 10, 3, 1'b0), 1'b1) : lvl(act_at(s - 20, 6, 2, 1'b0), 1'b1));
            wr_en = (s == 14 || s == 15);
            wr_addr = (s == 14) ? 4'd3 : 4'd5;
            wr_data = (s == 14) ? 8'd6 : 8'd2;
            @(negedge clk);
        end
        wr_en = 1'b0;

        // R8: counter write restarts and loads staged period
        cfg(0, 10, 4, 1'b0, 1'b1);
        for (int s = 0; s < 30; s++) begin
            chk("R8 counter write restart", int'(pwm_out[0]),
                (s < 6) ? lvl(act_at(s, 10, 4, 1'b0), 1'b1) : lvl(act_at(s - 6, 7, 4, 1'b0), 1'b1));
            wr_en = (s == 2 || s == 5);
            wr_addr = (s == 2) ? 4'd3 : 4'd7;
            wr_data = (s == 2) ? 8'd7 : 8'd0;
            @(negedge clk);
        end
        wr_en = 1'b0;

        // R9: center bit ignored while running
        cfg(0, 8, 3, 1'b0, 1'b1);
        for (int s = 0; s < 40; s++) begin
            chk("R9 alignment held while running", int'(pwm_out[0]), lvl(act_at(s, 8, 3, 1'b0), 1'b1));
            wr_en = (s == 4);
            wr_addr = 4'd0;
            wr_data = 8'b111;
            @(negedge clk);
        end
        wr_en = 1'b0;
        wr(0, 8'b010);
        chk("R6 disabled pol1 low", int'(pwm_out[0]), 0);

        // R10 R11: joined 16-bit lane
        wr(0, 0); wr(1, 0); wr(2, 1);
        wr(3, 8'h01); wr(4, 8'h2C); wr(5, 8'h00); wr(6, 8'h96);
        wr(0, 8'b011);
        chk("R10 high lane parked", int'(pwm_out[0]), 0);
        wr(1, 8'b011);
        for (int s = 0; s < 650; s++) begin
            string tg;
            tg = (s > 100) ? "R11 join held while enabled" : "R10 joined waveform";
            chk(tg, int'(pwm_out[1]), lvl(act_at(s, 300, 150, 1'b0), 1'b1));
            chk("R10 high lane parked", int'(pwm_out[0]), 0);
            wr_en = (s == 100 || s == 200);
            wr_addr = (s == 100) ? 4'd2 : 4'd7;
            wr_data = 8'd0;
            @(negedge clk);
        end
        wr_en = 1'b0;

        // R11: join cleared once both lanes stopped
        wr(0, 0); wr(1, 0); wr(2, 0); wr(6, 16);
        wr(1, 8'b011);
        run_lane(1, 44, 16, 1'b0, 1'b1, 100, 1, "R11 join cleared while stopped");

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule